// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers interrupt requests for a USB peripheral into a single interrupt pin. Three sub-groups (USB core endpoint events, DMA completions and general-purpose inputs) and one top-level group each hold a pending word. Each group also has a mask word. Pending bits are set by hardware event inputs or by software writes, and are cleared by software writes. The USB core group is split into a TX half and an RX half. Each half is reduced to its own summary bit in the top-level word. The DMA group is reduced to one summary bit. The top-level pending bits that are not masked drive the output pin.

The top level also has direct event bits. These include a core-general event (17), OTG timer expiry (16), VBUS sense change (15), ID change (14), device wakeup (13) and device ready (12). Core bus events occupy bits 7:0. A configuration register sets the pin polarity and selects level or pulsed output, with a programmable pulse length. The pin is held low whenever the global enable input is low.

Top module: `irq_aggregator`

## Requirements
- R1: Word registers sit at byte offsets: the core group at 0x40, the DMA group at 0x50, the GPIO group at 0x60 and the top group at 0x70. Within a group, +0x0 is the pending word (read-only), +0x4 is set, +0x8 is clear and +0xC is mask. Reads of +0x4 and +0x8 return the pending word. Unmapped or misaligned reads return 0, and writes to them are ignored.
- R2: A write to set ORs the data into the pending word, and a write to clear removes the bits that are 1 in the data. A zero data bit leaves its pending bit unchanged.
- R3: A 1 on an event input bit sets that pending bit. When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: Every mask register resets to all ones. A mask bit of 1 removes its pending bit from the summary and pin logic, and the mask registers read back as written.
- R5: Any unmasked core bit in 15:0 makes top-level bit 9 read as 1. Any unmasked core bit in 31:16 makes top-level bit 8 read as 1. Each summary bit reads 0 once its half has no unmasked bit.
- R6: Any unmasked DMA bit makes top-level bit 24 read as 1. Bit 24 reads 0 when no unmasked DMA bit remains.
- R7: Top-level bits 24, 9 and 8 reflect only the summaries. A software set of those bits is not retained.
- R8: Offset 0x38 reads 0x20 and ignores writes. The configuration register at 0x3C holds bits 20:16: release count 20:18, polarity 17 and pulse mode 16. It resets to 0, and its other bits read 0.
- R9: With polarity 1 the pin is active-high while any unmasked top-level bit is pending. With polarity 0 the pin is low while any such bit is pending and high otherwise.
- R10: While the enable input is low, the pin is low.
- R11: In level mode, the pin changes on the clock edge after the register write or event that changes the pending state, and not earlier.
- R12: In pulse mode, each rise of the unmasked-pending condition gives an active pulse of release count + 1 clocks. A condition that stays pending gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address within the block |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| core_evt | input | 32 | Hardware set pulses for the core group |
| dma_evt | input | 32 | Hardware set pulses for the DMA group |
| gpio_evt | input | 32 | Hardware set pulses for the GPIO group |
| top_evt | input | 32 | Hardware set pulses for the top-level group |
| irq_en | input | 1 | Global interrupt enable |
| irq_pin | output | 1 | Interrupt output pin |

## Verification
A wrong pending or mask bit is visible at once on reg_rdata, at the group's own offset and at its summary position in the top-level word. A wrong summary or polarity shows on irq_pin exactly one clock edge after the stimulus. A faulty pulse counter gives a pulse of the wrong length, which the bench measures clock by clock. A lost event-over-clear priority leaves a bit cleared that should read back set.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 8;
  localparam int unsigned RL_W = 3;
  localparam int unsigned NSUB = 3;

  localparam logic [AW-1:0] OFS_REV   = 8'h38;
  localparam logic [AW-1:0] OFS_CFG   = 8'h3C;
  localparam logic [AW-1:0] BASE_SUB0 = 8'h40;
  localparam logic [AW-1:0] BASE_TOP  = 8'h70;
  localparam logic [AW-1:0] GRP_STEP  = 8'h10;
  localparam logic [DW-1:0] REV_VALUE = 32'h20;

  localparam int unsigned BIT_DMA = 24;
  localparam int unsigned BIT_TX  = 9;
  localparam int unsigned BIT_RX  = 8;
  localparam int unsigned CFG_LO  = 16;
  localparam int unsigned CFG_W   = RL_W + 2;

  localparam logic [DW-1:0] SUMMARY_BITS =
    (DW'(1) << BIT_DMA) | (DW'(1) << BIT_TX) | (DW'(1) << BIT_RX);

  // Field order matches bits 20:16 of the configuration word.
  typedef struct packed {
    logic [RL_W-1:0] rlcyc;
    logic            pol;
    logic            pulse;
  } irq_cfg_t;

  function automatic logic any_unmasked(input logic [DW-1:0] src,
                                        input logic [DW-1:0] mask,
                                        input logic [DW-1:0] sel);
    return |(src & ~mask & sel);
  endfunction

  function automatic logic [DW-1:0] summary_word(input logic [DW-1:0] core_src,
                                                 input logic [DW-1:0] core_mask,
                                                 input logic [DW-1:0] dma_src,
                                                 input logic [DW-1:0] dma_mask);
    logic [DW-1:0] w;
    w = '0;
    w[BIT_TX]  = any_unmasked(core_src, core_mask, {{(DW/2){1'b0}}, {(DW/2){1'b1}}});
    w[BIT_RX]  = any_unmasked(core_src, core_mask, {{(DW/2){1'b1}}, {(DW/2){1'b0}}});
    w[BIT_DMA] = any_unmasked(dma_src, dma_mask, '1);
    return w;
  endfunction

  function automatic logic [AW-1:0] sub_base(input int unsigned idx);
    return BASE_SUB0 + AW'(idx) * GRP_STEP;
  endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group
  import irq_agg_pkg::*;
#(
  parameter logic [AW-1:0] BASE = 8'h40,
  parameter logic [DW-1:0] KEEP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] extra_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] rd_o
);
  localparam logic [AW-1:0] OFS_SET  = BASE + 8'h4;
  localparam logic [AW-1:0] OFS_CLR  = BASE + 8'h8;
  localparam logic [AW-1:0] OFS_MASK = BASE + 8'hC;

  logic [DW-1:0] src_q, mask_q, src_n;
  logic wr_set, wr_clr, wr_mask, rd_hit;

  assign wr_set  = wr_en && (addr == OFS_SET);
  assign wr_clr  = wr_en && (addr == OFS_CLR);
  assign wr_mask = wr_en && (addr == OFS_MASK);

  // An event bit overrides a clear landing in the same cycle.
  always_comb begin
    src_n = src_q;
    if (wr_clr) src_n = src_n & ~wdata;
    if (wr_set) src_n = src_n | wdata;
    src_n = (src_n | evt) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '1;
    end else begin
      src_q <= src_n;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign src_o  = src_q | extra_i;
  assign mask_o = mask_q;
  assign rd_hit = (addr[AW-1:4] == BASE[AW-1:4]) && (addr[1:0] == 2'b00);
  assign rd_o   = !rd_hit ? '0 : (addr[3:2] == 2'b11) ? mask_q : src_o;

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & KEEP) != '0) |=> ((src_q & $past(evt & KEEP)) == $past(evt & KEEP)));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && evt == '0) |=> ((src_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     any_i,
  input  logic     en_i,
  input  irq_cfg_t cfg_i,
  output logic     pin_o
);
  localparam int unsigned CW = RL_W + 1;

  logic          any_q, rise, active;
  logic [CW-1:0] left_q, left_n;

  assign rise = any_i & ~any_q;

  always_comb begin
    if (rise)              left_n = {1'b0, cfg_i.rlcyc} + CW'(1);
    else if (left_q != '0) left_n = left_q - CW'(1);
    else                   left_n = '0;
    active = cfg_i.pulse ? (left_n != '0) : any_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q  <= 1'b0;
      left_q <= '0;
      pin_o  <= 1'b0;
    end else begin
      any_q  <= any_i;
      left_q <= left_n;
      pin_o  <= en_i & (cfg_i.pol ? active : ~active);
    end
  end

  a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pin_o);

  a_r9_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.pulse && cfg_i.pol && en_i && any_i) |=> pin_o);

  a_r9_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.pulse && !cfg_i.pol && en_i && any_i) |=> !pin_o);

  a_r12_pulse_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && left_q != '0) |=> (left_q == CW'($past(left_q) - CW'(1))));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] core_evt,
  input  logic [DW-1:0] dma_evt,
  input  logic [DW-1:0] gpio_evt,
  input  logic [DW-1:0] top_evt,
  input  logic          irq_en,
  output logic          irq_pin
);
  logic [DW-1:0] sub_evt  [NSUB];
  logic [DW-1:0] sub_src  [NSUB];
  logic [DW-1:0] sub_mask [NSUB];
  logic [DW-1:0] sub_rd   [NSUB];
  logic [DW-1:0] summary, top_src, top_mask, top_rd, sub_rd_or;
  logic          any_pend;
  irq_cfg_t      cfg_q;

  assign sub_evt[0] = core_evt;
  assign sub_evt[1] = dma_evt;
  assign sub_evt[2] = gpio_evt;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    irq_group #(.BASE(sub_base(g)), .KEEP('1)) u_grp (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .evt(sub_evt[g]), .extra_i('0),
      .src_o(sub_src[g]), .mask_o(sub_mask[g]), .rd_o(sub_rd[g]));
  end

  assign summary = summary_word(sub_src[0], sub_mask[0], sub_src[1], sub_mask[1]);

  irq_group #(.BASE(BASE_TOP), .KEEP(~SUMMARY_BITS)) u_top (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .evt(top_evt), .extra_i(summary),
    .src_o(top_src), .mask_o(top_mask), .rd_o(top_rd));

  assign any_pend = any_unmasked(top_src, top_mask, '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (reg_wr && reg_addr == OFS_CFG) cfg_q <= reg_wdata[CFG_LO +: CFG_W];
  end

  irq_pin_stage u_pin (
    .clk(clk), .rst_n(rst_n), .any_i(any_pend), .en_i(irq_en),
    .cfg_i(cfg_q), .pin_o(irq_pin));

  always_comb begin
    sub_rd_or = '0;
    for (int i = 0; i < NSUB; i++) sub_rd_or = sub_rd_or | sub_rd[i];
    reg_rdata = sub_rd_or | top_rd;
    if (reg_addr == OFS_REV) reg_rdata = REV_VALUE;
    if (reg_addr == OFS_CFG) reg_rdata = DW'(cfg_q) << CFG_LO;
  end

  a_r7_summary_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((top_src & SUMMARY_BITS) == summary));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] core_evt = '0, dma_evt = '0, gpio_evt = '0, top_evt = '0;
  logic        irq_en = 1'b0;
  logic        irq_pin;
  int          n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_aggregator uut (.*);

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'h44, 32'h0001_0002, 8'h40, 32'h0001_0002}, // R2 set core
    '{8'h4C, 32'hFFFF_FFFD, 8'h70, 32'h0000_0200}, // R5 TX summary bit 9
    '{8'h4C, 32'hFFFE_FFFF, 8'h70, 32'h0000_0100}, // R5 RX summary bit 8
    '{8'h48, 32'h0001_0000, 8'h70, 32'h0000_0000}, // R5 summary drops after clear
    '{8'h00, 32'hFFFF_FFFF, 8'h48, 32'h0000_0002}, // R1 clear addr reads source
    '{8'h54, 32'h0000_0080, 8'h70, 32'h0000_0000}, // R4 DMA masked
    '{8'h5C, 32'hFFFF_FF7F, 8'h70, 32'h0100_0000}, // R6 DMA summary bit 24
    '{8'h74, 32'h0000_3001, 8'h70, 32'h0100_3001}, // R2 top set
    '{8'h74, 32'h0100_0000, 8'h70, 32'h0100_3001}, // R7 summary set ignored
    '{8'h5C, 32'hFFFF_FFFF, 8'h70, 32'h0000_3001}, // R7 bit 24 not held
    '{8'h78, 32'h0000_0001, 8'h70, 32'h0000_3000}, // R2 top clear
    '{8'h38, 32'h0000_FFFF, 8'h38, 32'h0000_0020}, // R8 revision
    '{8'h3C, 32'hFFFF_FFFF, 8'h3C, 32'h001F_0000}, // R8 config field
    '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0002}, // R1 source read-only
    '{8'h3C, 32'h0000_0000, 8'h64, 32'h0000_0000}, // R1 gpio set addr reads source
    '{8'h7C, 32'h1234_5678, 8'h7C, 32'h1234_5678}, // R4 mask readback
    '{8'h42, 32'hFFFF_FFFF, 8'h42, 32'h0000_0000}  // R1 misaligned
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_pulse(input string tag, input int exp);
    int hi;
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (irq_pin) hi++;
    end
    chk(tag, 32'(hi), 32'(exp));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // Reset state
    chk("R10 reset pin", 32'(irq_pin), 32'h0);
    rd("R4 mask reset", 8'h4C, 32'hFFFF_FFFF);
    rd("R1 source reset", 8'h70, 32'h0);
    rd("R8 config reset", 8'h3C, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd($sformatf("table step %0d", i), VEC[i].ra, VEC[i].exp);
    end

    // Pin behaviour
    do_reset();
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk("R9 idle high at polarity 0", 32'(irq_pin), 32'h1);
    wr(8'h74, 32'h0000_1000);
    wr(8'h7C, ~32'h0000_1000);
    chk("R11 not before the edge", 32'(irq_pin), 32'h1);
    @(negedge clk);
    chk("R9 low while pending, polarity 0", 32'(irq_pin), 32'h0);
    wr(8'h3C, 32'h0002_0000);
    chk("R11 polarity change not early", 32'(irq_pin), 32'h0);
    @(negedge clk);
    chk("R9 high while pending, polarity 1", 32'(irq_pin), 32'h1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 enable low forces pin low", 32'(irq_pin), 32'h0);
    irq_en = 1'b1;

    // Event against clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h78; reg_wdata = 32'h0000_2000; top_evt = 32'h0000_2000;
    @(negedge clk);
    reg_wr = 1'b0; top_evt = '0;
    rd("R3 event wins over clear", 8'h70, 32'h0000_3000);
    wr(8'h78, 32'h0000_2000);
    rd("R2 clear alone", 8'h70, 32'h0000_1000);
    @(negedge clk); core_evt = 32'h0010_0000;
    @(negedge clk); core_evt = '0;
    rd("R3 hardware event sets core bit", 8'h40, 32'h0010_0000);
    wr(8'h44, 32'h0);
    rd("R2 zero set bits no effect", 8'h40, 32'h0010_0000);

    // Pulse mode
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h000B_0000);
    @(negedge clk);
    chk("R12 idle pulse mode", 32'(irq_pin), 32'h0);
    wr(8'h74, 32'h0000_1000);
    count_pulse("R12 pulse width count 2", 3);
    wr(8'h78, 32'h0000_1000);
    wr(8'h3C, 32'h0003_0000);
    @(negedge clk);
    wr(8'h74, 32'h0000_1000);
    count_pulse("R12 pulse width count 0", 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule